// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block is the coherence controller for one small direct-mapped, write-back cache that sits on a shared bus with other caches. Its processor port takes load and store requests through a valid/ready handshake. Each line holds one data word, a tag and a three-valued state: invalid, shared or modified. Loads that hit and stores that hit a modified line complete in the cycle they are presented. All other accesses stall the processor while the controller requests the bus and runs one transaction. That transaction is a read, a read-exclusive, an invalidate-only upgrade, or a writeback of a dirty victim.

The controller also watches every transaction that other caches place on the bus. A snooped read that finds a dirty copy here is answered with the data, and the line drops to shared. A snooped read-exclusive or invalidate removes the local copy, so the next local access to that line misses. The bus command for a miss is chosen in the grant cycle, not when the request is raised. A line that is lost to a snoop while the controller waits for the bus is therefore fetched afresh and not merely upgraded. The testbench plays the arbiter, the memory and the other caches.

Top module: `coh_snoop_cache`

## Requirements
- R1: After reset every line is invalid (state code 2'b00), bus_req is low, and the first load to any address issues a read (bus_cmd 1).
- R2: A load miss issues bus_cmd 1 with the load address. It fills the line as shared (2'b01) with bus_rdata and then completes with that data.
- R3: A load that hits a shared or modified line completes with the cached word and raises no bus request.
- R4: A store that hits a modified line (2'b10) updates only the cache, raises no bus request, and a later load returns the stored word.
- R5: A store that hits a shared line issues an invalidate-only transaction (bus_cmd 3, no data) for that address. The line then becomes modified.
- R6: A store miss issues a read-exclusive (bus_cmd 2). The line is filled as modified, and the store data replaces the filled word.
- R7: A miss whose victim line is modified with a different tag first issues a writeback (bus_cmd 4). The writeback carries the victim's address (victim tag above the index bits) and its data on bus_wdata. A clean victim is replaced without a writeback.
- R8: A snooped read (snp_cmd 1) that hits a modified line raises snp_supply with the line's data on snp_data, and leaves the line shared.
- R9: A snooped read-exclusive (snp_cmd 2) that hits a line invalidates it. If the line was modified, the controller also supplies the data.
- R10: A snooped invalidate (snp_cmd 3) that hits a shared line invalidates it without supplying data.
- R11: A snoop that misses (line invalid or tag different), or a snooped read of a shared line, raises no snp_supply and leaves the line unchanged.
- R12: Only one bus transaction is outstanding. bus_req stays high from request to bus_done, and cpu_ready stays low throughout. A snoop to the processor's line index in the same cycle holds off cpu_ready.
- R13: A store that found its line shared, but lost the line to a snooped invalidation before the grant, issues a read-exclusive (bus_cmd 2) and not an upgrade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address: low bits index, high bits tag |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| bus_req | output | 1 | Bus request, held until bus_done |
| bus_gnt | input | 1 | One-cycle grant; command and address are broadcast in this cycle |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 invalidate, 4 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_done | input | 1 | Transaction finished; fill data on bus_rdata |
| bus_rdata | input | DATA_W | Fill data from memory or the owning cache |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache holds the line dirty and drives it |
| snp_data | output | DATA_W | Supplied line data |

## Verification
The bench builds the controller with a 6-bit address, 16-bit data and four lines, so two index bits and four tag bits. Three tags per index are enough to force evictions of clean and dirty victims on every line. A reference model of line states, together with a coherent image of memory, predicts the bus command in each grant, the writeback data, the snoop responses and every load value. Directed cases cover each state transition and the grant-time race. A pseudo-random sweep then mixes loads, stores and the three snoop kinds over all lines.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      LN_INV = 2'b00,
      LN_SHR = 2'b01,
      LN_MOD = 2'b10
   } line_st_e;

   typedef enum logic [2:0] {
      BC_NONE = 3'd0,
      BC_RD   = 3'd1,
      BC_RDX  = 3'd2,
      BC_UPG  = 3'd3,
      BC_WB   = 3'd4
   } bus_cmd_e;

   typedef enum logic [1:0] {
      F_IDLE = 2'd0,
      F_REQ  = 2'd1,
      F_WAIT = 2'd2
   } fsm_st_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IDX_W-1:0]       a_idx,
   input  logic                   lw_en,
   input  logic [1:0]             lw_state,
   input  logic                   lw_tag_en,
   input  logic [TAG_W-1:0]       lw_tag,
   input  logic                   lw_data_en,
   input  logic [DATA_W-1:0]      lw_data,
   output logic [1:0]             a_state,
   output logic [TAG_W-1:0]       a_tag,
   output logic [DATA_W-1:0]      a_data,
   input  logic [IDX_W-1:0]       b_idx,
   input  logic                   sn_en,
   input  logic [1:0]             sn_state,
   output logic [1:0]             b_state,
   output logic [TAG_W-1:0]       b_tag,
   output logic [DATA_W-1:0]      b_data,
   output logic [LINES-1:0][1:0]  st_all
);
   logic [LINES-1:0][TAG_W-1:0]  tag_q;
   logic [LINES-1:0][DATA_W-1:0] data_q;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_all[i] <= LN_INV;
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end else if (lw_en && a_idx == IDX_W'(i)) begin
            st_all[i] <= lw_state;
            if (lw_tag_en)  tag_q[i]  <= lw_tag;
            if (lw_data_en) data_q[i] <= lw_data;
         end else if (sn_en && b_idx == IDX_W'(i)) begin
            st_all[i] <= sn_state;
         end
      end

      // Line state never takes the unused code 2'b11.
      a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
         st_all[i] != 2'b11);
   end

   assign a_state = st_all[a_idx];
   assign a_tag   = tag_q[a_idx];
   assign a_data  = data_q[a_idx];
   assign b_state = st_all[b_idx];
   assign b_tag   = tag_q[b_idx];
   assign b_data  = data_q[b_idx];
endmodule

// File: rtl/coh_snoop_ctl.sv
module coh_snoop_ctl
   import coh_pkg::*;
#(
   parameter int TAG_W = 4
) (
   input  logic             snp_valid,
   input  logic [2:0]       snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic [1:0]       line_state,
   input  logic [TAG_W-1:0] line_tag,
   output logic             hit,
   output logic             supply,
   output logic             upd_en,
   output logic [1:0]       upd_state
);
   always_comb begin
      hit       = snp_valid && line_state != LN_INV && line_tag == snp_tag;
      supply    = 1'b0;
      upd_en    = 1'b0;
      upd_state = line_state;
      if (hit) begin
         unique case (snp_cmd)
            BC_RD: begin
               if (line_state == LN_MOD) begin
                  supply    = 1'b1;
                  upd_en    = 1'b1;
                  upd_state = LN_SHR;
               end
            end
            BC_RDX: begin
               supply    = line_state == LN_MOD;
               upd_en    = 1'b1;
               upd_state = LN_INV;
            end
            BC_UPG: begin
               upd_en    = 1'b1;
               upd_state = LN_INV;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/coh_ctrl_fsm.sv
module coh_ctrl_fsm
   import coh_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16,
   localparam int AW    = IDX_W + TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [IDX_W-1:0]  cpu_idx,
   input  logic [TAG_W-1:0]  cpu_tag,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              snp_block,
   output logic              cpu_ready,
   input  logic [1:0]        a_state,
   input  logic [TAG_W-1:0]  a_tag,
   input  logic [DATA_W-1:0] a_data,
   output logic              lw_en,
   output logic [1:0]        lw_state,
   output logic              lw_tag_en,
   output logic              lw_data_en,
   output logic [DATA_W-1:0] lw_data,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [2:0]        bus_cmd,
   output logic [AW-1:0]     bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_done,
   input  logic [DATA_W-1:0] bus_rdata
);
   fsm_st_e           st_q, st_d;
   logic [2:0]        cmd_q;
   logic [AW-1:0]     addr_q;
   logic [DATA_W-1:0] wdata_q;

   logic       hit, local_ok;
   logic [2:0] cmd_pick;

   always_comb begin
      hit      = a_state != LN_INV && a_tag == cpu_tag;
      local_ok = hit && (!cpu_write || a_state == LN_MOD);
      if (a_state == LN_MOD && a_tag != cpu_tag) cmd_pick = BC_WB;
      else if (!cpu_write)                       cmd_pick = BC_RD;
      else if (hit && a_state == LN_SHR)         cmd_pick = BC_UPG;
      else                                       cmd_pick = BC_RDX;
   end

   always_comb begin
      st_d       = st_q;
      cpu_ready  = 1'b0;
      lw_en      = 1'b0;
      lw_state   = LN_INV;
      lw_tag_en  = 1'b0;
      lw_data_en = 1'b0;
      lw_data    = cpu_wdata;
      bus_req    = 1'b0;
      bus_cmd    = BC_NONE;
      bus_addr   = addr_q;
      bus_wdata  = wdata_q;
      unique case (st_q)
         F_IDLE: begin
            if (cpu_valid && !snp_block) begin
               if (local_ok) begin
                  cpu_ready = 1'b1;
                  if (cpu_write) begin
                     lw_en      = 1'b1;
                     lw_state   = LN_MOD;
                     lw_data_en = 1'b1;
                  end
               end else begin
                  st_d = F_REQ;
               end
            end
         end
         F_REQ: begin
            bus_req   = 1'b1;
            bus_cmd   = cmd_pick;
            bus_addr  = (cmd_pick == BC_WB) ? {a_tag, cpu_idx} : {cpu_tag, cpu_idx};
            bus_wdata = a_data;
            if (bus_gnt) st_d = F_WAIT;
         end
         F_WAIT: begin
            bus_req = 1'b1;
            bus_cmd = cmd_q;
            if (bus_done) begin
               st_d  = F_IDLE;
               lw_en = 1'b1;
               unique case (cmd_q)
                  BC_RD: begin
                     lw_state   = LN_SHR;
                     lw_tag_en  = 1'b1;
                     lw_data_en = 1'b1;
                     lw_data    = bus_rdata;
                  end
                  BC_RDX: begin
                     lw_state   = LN_MOD;
                     lw_tag_en  = 1'b1;
                     lw_data_en = 1'b1;
                     lw_data    = bus_rdata;
                  end
                  BC_UPG:  lw_state = LN_MOD;
                  default: lw_state = LN_INV;
               endcase
            end
         end
         default: st_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= F_IDLE;
         cmd_q   <= BC_NONE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == F_REQ && bus_gnt) begin
            cmd_q   <= bus_cmd;
            addr_q  <= bus_addr;
            wdata_q <= bus_wdata;
         end
      end
   end

   a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_done |=> bus_req);
   a_r12_no_ready_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_req) && !$past(bus_done) |-> !cpu_ready);
   a_r2_fill_shared: assert property (@(posedge clk) disable iff (!rst_n)
      bus_done && bus_cmd == BC_RD |=> a_state == LN_SHR);
   a_r5_upgrade_to_mod: assert property (@(posedge clk) disable iff (!rst_n)
      bus_done && bus_cmd == BC_UPG |=> a_state == LN_MOD);
   a_r7_writeback_clears: assert property (@(posedge clk) disable iff (!rst_n)
      bus_done && bus_cmd == BC_WB |=> a_state == LN_INV);
   a_r12_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_req && bus_gnt) && bus_req |-> bus_cmd == $past(bus_cmd));
endmodule

// File: rtl/coh_snoop_cache.sv
module coh_snoop_cache
   import coh_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int LINES  = 4,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_done,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_supply,
   output logic [DATA_W-1:0] snp_data
);
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must leave at least one tag bit");
   end

   logic [IDX_W-1:0]  cpu_idx, snp_idx, snp_idx_q;
   logic [TAG_W-1:0]  cpu_tag, snp_tag;
   logic [1:0]        a_state, b_state, lw_state, sn_state;
   logic [TAG_W-1:0]  a_tag, b_tag;
   logic [DATA_W-1:0] a_data, b_data, lw_data;
   logic              lw_en, lw_tag_en, lw_data_en, sn_en, snp_hit, snp_block;
   logic [LINES-1:0][1:0] st_all;

   assign cpu_idx   = cpu_addr[IDX_W-1:0];
   assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
   assign snp_idx   = snp_addr[IDX_W-1:0];
   assign snp_tag   = snp_addr[ADDR_W-1:IDX_W];
   assign snp_block = snp_valid && snp_idx == cpu_idx;
   assign cpu_rdata = a_data;
   assign snp_data  = b_data;

   coh_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk, .rst_n,
      .a_idx(cpu_idx), .lw_en, .lw_state, .lw_tag_en, .lw_tag(cpu_tag),
      .lw_data_en, .lw_data, .a_state, .a_tag, .a_data,
      .b_idx(snp_idx), .sn_en, .sn_state, .b_state, .b_tag, .b_data, .st_all
   );

   coh_snoop_ctl #(.TAG_W(TAG_W)) u_snoop (
      .snp_valid, .snp_cmd, .snp_tag, .line_state(b_state), .line_tag(b_tag),
      .hit(snp_hit), .supply(snp_supply), .upd_en(sn_en), .upd_state(sn_state)
   );

   coh_ctrl_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
      .clk, .rst_n, .cpu_valid, .cpu_write, .cpu_idx, .cpu_tag, .cpu_wdata,
      .snp_block, .cpu_ready, .a_state, .a_tag, .a_data,
      .lw_en, .lw_state, .lw_tag_en, .lw_data_en, .lw_data,
      .bus_req, .bus_gnt, .bus_cmd, .bus_addr, .bus_wdata, .bus_done, .bus_rdata
   );

   always_ff @(posedge clk) begin
      if (!rst_n) snp_idx_q <= '0;
      else        snp_idx_q <= snp_idx;
   end

   a_r8_supply_leaves_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |=> st_all[snp_idx_q] != LN_MOD);
   a_r9_snoop_kills_line: assert property (@(posedge clk) disable iff (!rst_n)
      snp_hit && (snp_cmd == BC_RDX || snp_cmd == BC_UPG) |=> st_all[snp_idx_q] == LN_INV);
   a_r12_snoop_not_own: assert property (@(posedge clk) disable iff (!rst_n)
      !(snp_valid && bus_gnt));
   a_r12_snoop_holds_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && snp_idx == cpu_idx |-> !cpu_ready);
endmodule

// File: tb/coh_snoop_cache_bench.sv
module coh_snoop_cache_bench;
   localparam int AW = 6, DW = 16, NL = 4, IW = 2, TW = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cpu_valid = 1'b0, cpu_write = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req, bus_gnt = 1'b0, bus_done = 1'b0;
   logic [2:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata = '0;
   logic          snp_valid = 1'b0;
   logic [2:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_supply;
   logic [DW-1:0] snp_data;

   coh_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_coh_snoop_cache (
      .clk, .rst_n, .cpu_valid, .cpu_write, .cpu_addr, .cpu_wdata, .cpu_ready, .cpu_rdata,
      .bus_req, .bus_gnt, .bus_cmd, .bus_addr, .bus_wdata, .bus_done, .bus_rdata,
      .snp_valid, .snp_cmd, .snp_addr, .snp_supply, .snp_data
   );

   int n_chk = 0, n_fail = 0;
   logic [1:0]    r_st [NL];
   logic [TW-1:0] r_tag[NL];
   logic [DW-1:0] gmem [64];
   int ntx, last_cmd;
   logic [DW-1:0] rd;

   task automatic chk(bit ok, string rq, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   function automatic bit ref_hit(logic [AW-1:0] a);
      return r_st[a[IW-1:0]] != 2'b00 && r_tag[a[IW-1:0]] == a[AW-1:IW];
   endfunction

   function automatic int exp_cmd(bit wr, logic [AW-1:0] a);
      logic [IW-1:0] ix = a[IW-1:0];
      if (r_st[ix] == 2'b10 && r_tag[ix] != a[AW-1:IW]) return 4;
      if (!wr) return 1;
      if (r_st[ix] == 2'b01 && r_tag[ix] == a[AW-1:IW]) return 3;
      return 2;
   endfunction

   // Called at a falling edge; returns at a falling edge.
   task automatic snoop(int cmd, logic [AW-1:0] a, logic [DW-1:0] nv, string rq);
      logic [IW-1:0] ix = a[IW-1:0];
      bit h = ref_hit(a);
      bit es = h && r_st[ix] == 2'b10 && (cmd == 1 || cmd == 2);
      snp_valid = 1'b1; snp_cmd = 3'(cmd); snp_addr = a;
      #1;
      chk(snp_supply == es, rq, snp_supply, es);
      if (es) chk(snp_data == gmem[a], rq, snp_data, gmem[a]);
      @(posedge clk); #1 snp_valid = 1'b0;
      if (h) begin
         if (cmd == 1 && r_st[ix] == 2'b10) r_st[ix] = 2'b01;
         if (cmd == 2 || cmd == 3) r_st[ix] = 2'b00;
      end
      if (cmd == 2 || cmd == 3) gmem[a] = nv;
      @(negedge clk);
   endtask

   task automatic cpu_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd, bit race,
                         output logic [DW-1:0] rdv);
      logic [IW-1:0] ix = a[IW-1:0];
      int guard = 0;
      bit raced = 1'b0;
      ntx = 0; last_cmd = 0; rdv = '0;
      cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
      forever begin
         #1;
         if (cpu_ready) begin
            rdv = cpu_rdata;
            break;
         end
         if (bus_req) begin
            if (race && !raced) begin
               raced = 1'b1;
               snoop(2, a, wd ^ 16'h5a5a, "R13");
               continue;
            end else begin
               int e = exp_cmd(wr, a);
               logic [AW-1:0] ea = (e == 4) ? {r_tag[ix], ix} : a;
               string rq = raced ? "R13" : (e == 1 ? "R2" : e == 2 ? "R6" : e == 3 ? "R5" : "R7");
               chk(bus_cmd == 3'(e), rq, bus_cmd, e);
               chk(bus_addr == ea, rq, bus_addr, ea);
               if (e == 4) chk(bus_wdata == gmem[ea], "R7", bus_wdata, gmem[ea]);
               bus_gnt = 1'b1;
               @(posedge clk); #1 bus_gnt = 1'b0;
               @(negedge clk);
               chk(bus_req == 1'b1, "R12", bus_req, 1);
               bus_done = 1'b1; bus_rdata = gmem[ea];
               @(posedge clk); #1 bus_done = 1'b0;
               case (e)
                  1: begin r_st[ix] = 2'b01; r_tag[ix] = a[AW-1:IW]; end
                  2: begin r_st[ix] = 2'b10; r_tag[ix] = a[AW-1:IW]; end
                  3: r_st[ix] = 2'b10;
                  default: r_st[ix] = 2'b00;
               endcase
               ntx++; last_cmd = e;
               @(negedge clk);
            end
         end else begin
            @(negedge clk);
         end
         guard++;
         if (guard > 40) begin
            chk(1'b0, "R12", 0, 1);
            break;
         end
      end
      @(posedge clk); #1 cpu_valid = 1'b0;
      if (wr) begin
         gmem[a] = wd; r_st[ix] = 2'b10; r_tag[ix] = a[AW-1:IW];
      end else begin
         chk(rdv == gmem[a], "R2", rdv, gmem[a]);
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] lf = 16'hace1;
      for (int i = 0; i < 64; i++) gmem[i] = 16'(16'h1000 + i * 37);
      for (int i = 0; i < NL; i++) begin r_st[i] = 2'b00; r_tag[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_req == 1'b0, "R1", bus_req, 0);
      chk(cpu_ready == 1'b0, "R1", cpu_ready, 0);

      // R1, R2: first load misses and fills shared
      cpu_op(0, 6'h05, '0, 0, rd);
      chk(ntx == 1 && last_cmd == 1, "R1", last_cmd, 1);
      // R3: load hit
      cpu_op(0, 6'h05, '0, 0, rd);
      chk(ntx == 0, "R3", ntx, 0);
      // R5: store to shared -> upgrade; R4: store to modified
      cpu_op(1, 6'h05, 16'hbeef, 0, rd);
      chk(ntx == 1 && last_cmd == 3, "R5", last_cmd, 3);
      cpu_op(1, 6'h05, 16'hcafe, 0, rd);
      chk(ntx == 0, "R4", ntx, 0);
      cpu_op(0, 6'h05, '0, 0, rd);
      chk(ntx == 0 && rd == 16'hcafe, "R4", rd, 16'hcafe);
      // R8: snooped read of dirty line, then store needs upgrade
      snoop(1, 6'h05, '0, "R8");
      cpu_op(1, 6'h05, 16'h1234, 0, rd);
      chk(ntx == 1 && last_cmd == 3, "R8", last_cmd, 3);
      // R9: snooped read-exclusive of dirty line, then load misses
      snoop(2, 6'h05, 16'h7777, "R9");
      cpu_op(0, 6'h05, '0, 0, rd);
      chk(ntx == 1 && rd == 16'h7777, "R9", rd, 16'h7777);
      // R10: snooped invalidate of shared line
      snoop(3, 6'h05, 16'h8888, "R10");
      cpu_op(0, 6'h05, '0, 0, rd);
      chk(ntx == 1 && rd == 16'h8888, "R10", ntx, 1);
      // R11: snooped read of shared line is harmless
      snoop(1, 6'h05, '0, "R11");
      cpu_op(0, 6'h05, '0, 0, rd);
      chk(ntx == 0, "R11", ntx, 0);
      // R6: store miss
      cpu_op(1, 6'h02, 16'h4242, 0, rd);
      chk(ntx == 1 && last_cmd == 2, "R6", last_cmd, 2);
      cpu_op(0, 6'h02, '0, 0, rd);
      chk(ntx == 0 && rd == 16'h4242, "R6", rd, 16'h4242);
      // R11: snoop with a different tag leaves the dirty line alone
      snoop(2, 6'h16, 16'h0101, "R11");
      cpu_op(0, 6'h02, '0, 0, rd);
      chk(ntx == 0 && rd == 16'h4242, "R11", rd, 16'h4242);
      // R7: dirty victim written back, clean victim dropped
      cpu_op(0, 6'h0e, '0, 0, rd);
      chk(ntx == 2, "R7", ntx, 2);
      cpu_op(0, 6'h11, '0, 0, rd);
      chk(ntx == 1, "R7", ntx, 1);
      // R12: a snoop to the same index holds off a load hit
      cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 6'h0e;
      snp_valid = 1'b1; snp_cmd = 3'd1; snp_addr = 6'h3e;
      #1 chk(cpu_ready == 1'b0, "R12", cpu_ready, 0);
      @(posedge clk); #1 snp_valid = 1'b0;
      @(negedge clk);
      #1 chk(cpu_ready == 1'b1, "R12", cpu_ready, 1);
      @(posedge clk); #1 cpu_valid = 1'b0;
      @(negedge clk);
      // R13: shared line lost while awaiting the grant
      cpu_op(1, 6'h0e, 16'h9999, 1, rd);
      chk(ntx == 1 && last_cmd == 2, "R13", last_cmd, 2);
      cpu_op(0, 6'h0e, '0, 0, rd);
      chk(rd == 16'h9999, "R13", rd, 16'h9999);

      // Sweep over all lines with three tags each
      for (int it = 0; it < 400; it++) begin
         logic [AW-1:0] a;
         int op;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         a  = {4'((lf[7:4]) % 3), lf[1:0]};
         op = int'(lf[11:8]) % 5;
         case (op)
            0, 1: cpu_op(0, a, '0, 0, rd);
            2:    cpu_op(1, a, 16'(lf ^ 16'h3c3c), 0, rd);
            3:    snoop(1, a, '0, "R8");
            default: begin
               if ((ref_hit(a) && r_st[a[IW-1:0]] == 2'b10) || lf[12])
                  snoop(2, a, 16'(lf + 16'h0f0f), "R9");
               else
                  snoop(3, a, 16'(lf + 16'h0f0f), "R10");
            end
         endcase
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule